// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds eight single-bit ownership tokens that a left port and a right port share. Both ports are synchronous to one clock. Each port has its own select, write strobe, read strobe, 3-bit token index and 1-bit data line.

To claim a token, a port writes 0 to it. The port then reads the token back to learn whether it won. To give a token up, the owning port writes 1 to it. A request made while the other port holds the token is remembered as pending. The token passes to the waiting port as soon as the holder releases it. When both ports claim the same free token in the same cycle, the left port always wins, and the right port's claim becomes pending.

Each read returns the token state from before that clock edge, on bit 0 of the port's read data. The value is 0 when the reading port owns the token and 1 otherwise. It appears on the read data output one cycle after the read strobe and is held until the next read.

Top module: `sem_dual_top`

## Requirements
- R1: After reset, all eight tokens are free and nothing is pending, so every read from either port returns 1.
- R2: A left write of 0 to a free token gives that token to the left port. A later left read returns 0 and a right read returns 1.
- R3: A right write of 0 to a free token gives that token to the right port. A later right read returns 0 and a left read returns 1.
- R4: A write of 0 to a token that the other port holds records a pending request. The requester keeps reading 1 while the holder keeps the token.
- R5: When the holder writes 1 and the other port has a pending request, ownership moves to the other port at that same clock edge, and the pending request is cleared.
- R6: When the holder writes 1 and nothing is pending, the token becomes free.
- R7: When both ports write 0 to the same free token in one cycle, the left port wins and the right request becomes pending.
- R8: A write of 1 to a token that the port does not own clears that port's pending request and has no other effect.
- R9: Strobes take effect only while the port's select is 1. A write without select changes no token. A read without select leaves the read data unchanged.
- R10: An operation on one token index leaves every other token unchanged.
- R11: A read returns the state from before the edge at which it is sampled, and the value appears on the read data output one cycle later. A port's read and write in the same cycle therefore return the state from before the write.
- R12: When the holder's release and the other port's claim land in the same cycle, the claiming port obtains the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l_sel_i | input | 1 | Left semaphore select |
| l_wr_i | input | 1 | Left write strobe |
| l_rd_i | input | 1 | Left read strobe |
| l_idx_i | input | 3 | Left token index |
| l_wdata_i | input | 1 | Left write data (0 claims, 1 releases) |
| l_rdata_o | output | 1 | Left read status (0 means the left port owns the token) |
| r_sel_i | input | 1 | Right semaphore select |
| r_wr_i | input | 1 | Right write strobe |
| r_rd_i | input | 1 | Right read strobe |
| r_idx_i | input | 3 | Right token index |
| r_wdata_i | input | 1 | Right write data (0 claims, 1 releases) |
| r_rdata_o | output | 1 | Right read status (0 means the right port owns the token) |

## Verification
Two kinds of operation can fall into the same cycle. The first pair is a claim from each port on the same free token. The second pair is a release by the holder together with a claim by the other port. The bench drives both ports in the same cycle with matching indices. A behavioural reference model, kept in integer arrays, predicts the resulting owner and pending flags. The outcome is judged by the read-back status on both ports on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wdata_i,
  output logic [N_SEM-1:0] req_o,
  output logic [N_SEM-1:0] rel_o
);
  logic wr_en;
  assign wr_en = sel_i & wr_i;

  for (genvar g = 0; g < N_SEM; g++) begin : g_dec
    logic hit;
    assign hit      = wr_en && (idx_i == IDX_W'(g));
    assign req_o[g] = hit & ~wdata_i;
    assign rel_o[g] = hit & wdata_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e own_q, own_n;
  logic   pl_q, pl_n, pr_q, pr_n;

  // order: releases, hand-over to a waiter, then claims (left first)
  always_comb begin
    own_n = own_q;
    pl_n  = pl_q;
    pr_n  = pr_q;
    if (rel_l_i) begin
      if (own_n == OWN_LEFT) own_n = OWN_NONE;
      pl_n = 1'b0;
    end
    if (rel_r_i) begin
      if (own_n == OWN_RIGHT) own_n = OWN_NONE;
      pr_n = 1'b0;
    end
    if (own_n == OWN_NONE) begin
      if (pl_n) begin
        own_n = OWN_LEFT;
        pl_n  = 1'b0;
      end else if (pr_n) begin
        own_n = OWN_RIGHT;
        pr_n  = 1'b0;
      end
    end
    if (req_l_i) begin
      if (own_n == OWN_NONE) own_n = OWN_LEFT;
      else if (own_n != OWN_LEFT) pl_n = 1'b1;
    end
    if (req_r_i) begin
      if (own_n == OWN_NONE) own_n = OWN_RIGHT;
      else if (own_n != OWN_RIGHT) pr_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= OWN_NONE;
      pl_q  <= 1'b0;
      pr_q  <= 1'b0;
    end else begin
      own_q <= own_n;
      pl_q  <= pl_n;
      pr_q  <= pr_n;
    end
  end

  assign own_l_o = (own_q == OWN_LEFT);
  assign own_r_o = (own_q == OWN_RIGHT);

  // R4: a holder never waits on its own token
  p_no_self_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((own_q == OWN_LEFT) && pl_q) && !((own_q == OWN_RIGHT) && pr_q));

  // R2: a lone left claim on a free token wins it
  p_grant_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_l_i && !req_r_i && own_q == OWN_NONE && !pl_q && !pr_q) |=> own_l_o);

  // R7: a tie on a free token goes to the left, and the right waits
  p_tie_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_l_i && req_r_i && own_q == OWN_NONE && !pl_q && !pr_q) |=> (own_l_o && pr_q));

  // R5: a left release hands the token to a waiting right port
  p_handover_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_l_i && !rel_r_i && own_q == OWN_LEFT && pr_q) |=> (own_r_o && !pr_q));

  // R10: an untouched token holds its state
  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_l_i || rel_l_i || req_r_i || rel_r_i) |=> ($stable(own_q) && $stable(pl_q) && $stable(pr_q)));
endmodule

// File: rtl/sem_dual_top.sv
module sem_dual_top #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l_sel_i,
  input  logic             l_wr_i,
  input  logic             l_rd_i,
  input  logic [IDX_W-1:0] l_idx_i,
  input  logic             l_wdata_i,
  output logic             l_rdata_o,
  input  logic             r_sel_i,
  input  logic             r_wr_i,
  input  logic             r_rd_i,
  input  logic [IDX_W-1:0] r_idx_i,
  input  logic             r_wdata_i,
  output logic             r_rdata_o
);
  logic [N_SEM-1:0] req_l, rel_l, req_r, rel_r, own_l, own_r;

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_l (
    .sel_i(l_sel_i), .wr_i(l_wr_i), .idx_i(l_idx_i), .wdata_i(l_wdata_i),
    .req_o(req_l), .rel_o(rel_l)
  );

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_r (
    .sel_i(r_sel_i), .wr_i(r_wr_i), .idx_i(r_idx_i), .wdata_i(r_wdata_i),
    .req_o(req_r), .rel_o(rel_r)
  );

  for (genvar g = 0; g < N_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_l_i(req_l[g]),
      .rel_l_i(rel_l[g]),
      .req_r_i(req_r[g]),
      .rel_r_i(rel_r[g]),
      .own_l_o(own_l[g]),
      .own_r_o(own_r[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_o <= 1'b1;
      r_rdata_o <= 1'b1;
    end else begin
      if (l_sel_i && l_rd_i) l_rdata_o <= ~own_l[l_idx_i];
      if (r_sel_i && r_rd_i) r_rdata_o <= ~own_r[r_idx_i];
    end
  end

  // R9: read data only moves on a selected read
  p_hold_rdata_l_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_sel_i && l_rd_i) |=> $stable(l_rdata_o));
  p_hold_rdata_r_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(r_sel_i && r_rd_i) |=> $stable(r_rdata_o));

  // R2/R3: one owner at most per token
  p_single_owner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);
endmodule

// File: tb/sem_dual_top_tb.sv
`timescale 1ns/1ps
module sem_dual_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_rd = 0, l_wd = 0;
  logic r_sel = 0, r_wr = 0, r_rd = 0, r_wd = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic l_rdata, r_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model: 0 free, 1 left, 2 right
  int own [8];
  bit pl [8];
  bit pr [8];
  bit exp_l = 1, exp_r = 1;

  always #4 clk = ~clk;

  sem_dual_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_i(l_sel), .l_wr_i(l_wr), .l_rd_i(l_rd), .l_idx_i(l_idx), .l_wdata_i(l_wd), .l_rdata_o(l_rdata),
    .r_sel_i(r_sel), .r_wr_i(r_wr), .r_rd_i(r_rd), .r_idx_i(r_idx), .r_wdata_i(r_wd), .r_rdata_o(r_rdata)
  );

  task automatic model_step();
    bit lw, rw;
    if (l_sel && l_rd) exp_l = (own[l_idx] == 1) ? 1'b0 : 1'b1;
    if (r_sel && r_rd) exp_r = (own[r_idx] == 2) ? 1'b0 : 1'b1;
    lw = l_sel && l_wr;
    rw = r_sel && r_wr;
    if (lw && l_wd) begin
      if (own[l_idx] == 1) own[l_idx] = 0;
      pl[l_idx] = 0;
    end
    if (rw && r_wd) begin
      if (own[r_idx] == 2) own[r_idx] = 0;
      pr[r_idx] = 0;
    end
    for (int i = 0; i < 8; i++) begin
      if (own[i] == 0 && pl[i]) begin own[i] = 1; pl[i] = 0; end
      else if (own[i] == 0 && pr[i]) begin own[i] = 2; pr[i] = 0; end
    end
    if (lw && !l_wd) begin
      if (own[l_idx] == 0) own[l_idx] = 1;
      else if (own[l_idx] == 2) pl[l_idx] = 1;
    end
    if (rw && !r_wd) begin
      if (own[r_idx] == 0) own[r_idx] = 2;
      else if (own[r_idx] == 1) pr[r_idx] = 1;
    end
  endtask

  task automatic check(string tag);
    tests++;
    if (l_rdata !== exp_l || r_rdata !== exp_r) begin
      fails++;
      $display("FAIL %s: left=%b right=%b expected left=%b right=%b", tag, l_rdata, r_rdata, exp_l, exp_r);
    end
  endtask

  // one clock with both ports driven; compared after the edge
  task automatic cyc(string tag,
                     bit ls, bit lwr, bit lrd, int li, bit ld,
                     bit rs, bit rwr, bit rrd, int ri, bit rd);
    @(negedge clk);
    l_sel = ls; l_wr = lwr; l_rd = lrd; l_idx = 3'(li); l_wd = ld;
    r_sel = rs; r_wr = rwr; r_rd = rrd; r_idx = 3'(ri); r_wd = rd;
    model_step();
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic rd_both(string tag, int i);
    cyc(tag, 1, 0, 1, i, 0, 1, 0, 1, i, 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) rd_both("R1 reset all free", i);

    cyc("R2 left claim", 1, 1, 0, 3, 0, 0, 0, 0, 0, 0);
    rd_both("R2 left owns", 3);
    cyc("R4 right waits", 0, 0, 0, 0, 0, 1, 1, 0, 3, 0);
    rd_both("R4 right still 1", 3);
    cyc("R5 left release", 1, 1, 0, 3, 1, 0, 0, 0, 0, 0);
    rd_both("R5 handed to right", 3);
    cyc("R6 right release", 0, 0, 0, 0, 0, 1, 1, 0, 3, 1);
    rd_both("R6 free again", 3);

    cyc("R3 right claim", 0, 0, 0, 0, 0, 1, 1, 0, 5, 0);
    rd_both("R3 right owns", 5);

    cyc("R7 tie", 1, 1, 0, 6, 0, 1, 1, 0, 6, 0);
    rd_both("R7 left wins", 6);
    cyc("R7 left release", 1, 1, 0, 6, 1, 0, 0, 0, 0, 0);
    rd_both("R7 right was pending", 6);

    cyc("R8 left claim", 1, 1, 0, 2, 0, 0, 0, 0, 0, 0);
    cyc("R8 right waits", 0, 0, 0, 0, 0, 1, 1, 0, 2, 0);
    cyc("R8 right withdraws", 0, 0, 0, 0, 0, 1, 1, 0, 2, 1);
    rd_both("R8 left keeps", 2);
    cyc("R8 left release", 1, 1, 0, 2, 1, 0, 0, 0, 0, 0);
    rd_both("R8 no handover", 2);
    cyc("R8 stray release", 0, 0, 0, 0, 0, 1, 1, 0, 5, 1);
    rd_both("R8 stray release frees own", 5);
    cyc("R8 left stray release", 1, 1, 0, 6, 1, 0, 0, 0, 0, 0);
    rd_both("R8 right keeps 6", 6);

    cyc("R9 unselected write", 0, 1, 0, 1, 0, 0, 1, 0, 1, 0);
    rd_both("R9 token 1 free", 1);
    cyc("R9 set left view", 1, 0, 1, 6, 0, 1, 0, 1, 6, 0);
    cyc("R9 unselected read", 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    cyc("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    cyc("R10 right claim 0", 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    for (int i = 1; i < 8; i++) rd_both("R10 others", i);
    rd_both("R10 token 0", 0);

    cyc("R11 claim and read", 1, 1, 1, 4, 0, 1, 0, 1, 4, 0);
    rd_both("R11 next read", 4);

    cyc("R12 left claim", 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R12 release and claim", 1, 1, 0, 1, 1, 1, 1, 0, 1, 0);
    rd_both("R12 right gets it", 1);
    cyc("R12 swap back", 1, 1, 0, 1, 0, 1, 1, 0, 1, 1);
    rd_both("R12 left gets it", 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule